// File: doc/BRIEF.md
# Configuration EEPROM Access Sequencer

This block sits between a host register port and an external configuration EEPROM. Through a handful of registers the host asks for single-byte reads or writes at an address it chooses. It can also start a burst that copies a table of records from the EEPROM into on-chip memory. The EEPROM wire protocol is handled elsewhere. Here the EEPROM is reached through a byte port: a request is held until it is acknowledged, with address, direction and write byte alongside.

A burst is a list of six-byte records. Each record holds a 16-bit destination word (low byte first) and then a 32-bit data word (low byte first). Each record becomes one 32-bit write on the memory port. The word address on that port is 24 bits: nine bits from the base register on top, and the low 15 bits of the record's destination word below. A destination word of 0xFFFF ends the list. The sequencer remembers where the last EEPROM access stopped. A burst therefore starts at address 0 only if nothing has touched the EEPROM since reset; otherwise it picks up at the byte after the last one accessed.

Top module: `eep_access_seq`

## Requirements
- R1: After reset, every register reads 0, `ee_req` is low and `mem_we` is low. Register select values: 0 control, 1 address, 2 data, 3 base, 4 burst-start.
- R2: Writing 1 to control bit 0 causes exactly one EEPROM byte write. The byte is data[7:0] and the location is address[15:0]. Control bit 0 reads 1 from the write until that transfer is acknowledged, then reads 0. Writing 0 to a request bit has no effect.
- R3: Writing 1 to control bit 1 causes exactly one EEPROM byte read at the address register. The returned byte is loaded into data[7:0], and control bit 1 reads 0 once the data is valid.
- R4: A burst started before any EEPROM access since reset reads from EEPROM address 0 upward.
- R5: A burst started after a single access begins at the address after that access. A burst that follows a burst continues after the last byte the earlier one read.
- R6: Each burst record is read as six bytes: destination word low then high, then data word low to high. It produces one memory write whose data is the four data bytes, little-endian.
- R7: The memory address of a record is {base[8:0], destination[14:0]}. Bit 15 of the destination word is ignored.
- R8: A destination word of 0xFFFF ends the burst after its two bytes. No memory write is made for it, and burst-start bit 0 returns to 0.
- R9: Requests set while another operation runs are held, not dropped. Among pending requests, the write is served before the read, and the read before the burst.
- R10: At most one EEPROM byte request is outstanding. `ee_req`, `ee_addr`, `ee_we` and `ee_wdata` hold steady until `ee_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_en | input | 1 | Host register write strobe |
| hw_sel | input | 3 | Register selected for write |
| hw_data | input | 32 | Host write data |
| hr_sel | input | 3 | Register selected for read |
| hr_data | output | 32 | Read data for `hr_sel`, combinational |
| ee_req | output | 1 | EEPROM byte request |
| ee_we | output | 1 | 1 = byte write, 0 = byte read |
| ee_addr | output | 16 | EEPROM byte address |
| ee_wdata | output | 8 | Byte to write |
| ee_ack | input | 1 | Byte transfer accepted; read data valid |
| ee_rdata | input | 8 | Byte read from the EEPROM |
| mem_we | output | 1 | Memory word write strobe |
| mem_addr | output | 24 | Memory word address |
| mem_wdata | output | 32 | Memory word data |

## Verification
A wrong saved resume address or a lost history flag shows at the next burst. The very first EEPROM byte request then goes to the wrong address, which the bench catches at that request's acknowledge. A fault in record assembly or base merging shows on the first memory write, one cycle after the sixth byte of a record. A fault in the request bits or the priority shows as the wrong order of byte transfers, or as a status bit that reads wrongly before the host polls to idle.

// File: rtl/eep_pkg.sv
package eep_pkg;

    localparam int HOST_W    = 32;
    localparam int SEL_W     = 3;
    localparam int BYTE_W    = 8;
    localparam int AWORD_W   = 16;
    localparam int DWORD_W   = 32;
    localparam int REC_BYTES = (AWORD_W + DWORD_W) / BYTE_W;
    localparam int IDX_W     = $clog2(REC_BYTES);
    localparam logic [AWORD_W-1:0] END_MARK = '1;

    // request bit positions inside the pending vector
    localparam int PB_WR  = 0;
    localparam int PB_RD  = 1;
    localparam int PB_BST = 2;
    localparam int PEND_W = 3;

    typedef enum logic [SEL_W-1:0] {
        RSEL_CTRL  = 3'd0,
        RSEL_ADDR  = 3'd1,
        RSEL_DATA  = 3'd2,
        RSEL_BASE  = 3'd3,
        RSEL_BURST = 3'd4
    } rsel_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_BURST = 2'd3
    } op_e;

    // fixed service order among pending requests
    function automatic op_e pick_op(input logic [PEND_W-1:0] p);
        if (p[PB_WR])       return OP_WRITE;
        else if (p[PB_RD])  return OP_READ;
        else if (p[PB_BST]) return OP_BURST;
        else                return OP_NONE;
    endfunction

endpackage

// File: rtl/eep_cfg_regs.sv
module eep_cfg_regs
    import eep_pkg::*;
#(
    parameter int EE_AW  = 16,
    parameter int BASE_W = 9
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 hw_en,
    input  logic [SEL_W-1:0]     hw_sel,
    input  logic [HOST_W-1:0]    hw_data,
    input  logic [SEL_W-1:0]     hr_sel,
    output logic [HOST_W-1:0]    hr_data,
    input  logic [PEND_W-1:0]    done_i,
    input  logic                 rd_load,
    input  logic [BYTE_W-1:0]    rd_byte,
    output logic [PEND_W-1:0]    pend_q,
    output logic [EE_AW-1:0]     addr_q,
    output logic [BYTE_W-1:0]    data_q,
    output logic [BASE_W-1:0]    base_q
);

    logic [PEND_W-1:0] set_req;

    always_comb begin
        set_req = '0;
        if (hw_en && hw_sel == RSEL_CTRL) begin
            set_req[PB_WR] = hw_data[0];
            set_req[PB_RD] = hw_data[1];
        end
        if (hw_en && hw_sel == RSEL_BURST)
            set_req[PB_BST] = hw_data[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            addr_q <= '0;
            data_q <= '0;
            base_q <= '0;
        end else begin
            // completion clears; a repeat request for the running op merges into it
            pend_q <= (pend_q | set_req) & ~done_i;
            if (hw_en && hw_sel == RSEL_ADDR)
                addr_q <= hw_data[EE_AW-1:0];
            if (hw_en && hw_sel == RSEL_BASE)
                base_q <= hw_data[BASE_W-1:0];
            if (rd_load)
                data_q <= rd_byte;
            else if (hw_en && hw_sel == RSEL_DATA)
                data_q <= hw_data[BYTE_W-1:0];
        end
    end

    always_comb begin
        hr_data = '0;
        case (hr_sel)
            RSEL_CTRL:  hr_data[1:0]        = {pend_q[PB_RD], pend_q[PB_WR]};
            RSEL_ADDR:  hr_data[EE_AW-1:0]  = addr_q;
            RSEL_DATA:  hr_data[BYTE_W-1:0] = data_q;
            RSEL_BASE:  hr_data[BASE_W-1:0] = base_q;
            RSEL_BURST: hr_data[0]          = pend_q[PB_BST];
            default:    hr_data             = '0;
        endcase
    end

    // R2: a write request bit only drops when the sequencer reports the write done
    a_r2_wr_clear_on_done: assert property (@(posedge clk) disable iff (rst)
        $fell(pend_q[PB_WR]) |-> $past(done_i[PB_WR]));

    // R3: a read request bit only drops together with a data load
    a_r3_rd_clear_with_load: assert property (@(posedge clk) disable iff (rst)
        $fell(pend_q[PB_RD]) |-> $past(rd_load));

endmodule

// File: rtl/eep_rec_pack.sv
module eep_rec_pack
    import eep_pkg::*;
#(
    parameter int BASE_W = 9,
    localparam int LOW_W  = AWORD_W - 1,
    localparam int MEM_AW = BASE_W + LOW_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 byte_vld,
    input  logic [IDX_W-1:0]     byte_idx,
    input  logic [BYTE_W-1:0]    byte_in,
    input  logic [BASE_W-1:0]    base,
    output logic                 end_mark,
    output logic                 mem_we,
    output logic [MEM_AW-1:0]    mem_addr,
    output logic [DWORD_W-1:0]   mem_wdata
);

    localparam int AW_BYTES = AWORD_W / BYTE_W;
    localparam int DW_BYTES = DWORD_W / BYTE_W;
    localparam int LAST_IDX = REC_BYTES - 1;

    logic [AWORD_W-1:0]        aword;
    logic [DWORD_W-BYTE_W-1:0] dlow;

    assign end_mark = (byte_idx == IDX_W'(AW_BYTES - 1)) &&
                      ({byte_in, aword[BYTE_W-1:0]} == END_MARK);

    always_ff @(posedge clk) begin
        if (rst) begin
            aword     <= '0;
            dlow      <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= 1'b0;
            if (byte_vld) begin
                for (int i = 0; i < AW_BYTES; i++)
                    if (byte_idx == IDX_W'(i))
                        aword[i*BYTE_W +: BYTE_W] <= byte_in;
                for (int j = 0; j < DW_BYTES - 1; j++)
                    if (byte_idx == IDX_W'(AW_BYTES + j))
                        dlow[j*BYTE_W +: BYTE_W] <= byte_in;
                if (byte_idx == IDX_W'(LAST_IDX)) begin
                    mem_we    <= 1'b1;
                    mem_addr  <= {base, aword[LOW_W-1:0]};
                    mem_wdata <= {byte_in, dlow};
                end
            end
        end
    end

    // R6: a memory write always follows the final byte of a record
    a_r6_write_after_last_byte: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> $past(byte_vld) && $past(byte_idx) == IDX_W'(LAST_IDX));

endmodule

// File: rtl/eep_seq.sv
module eep_seq
    import eep_pkg::*;
#(
    parameter int EE_AW  = 16,
    parameter int BASE_W = 9
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [PEND_W-1:0]    pend,
    input  logic [EE_AW-1:0]     addr_q,
    input  logic [BYTE_W-1:0]    data_q,
    input  logic [BASE_W-1:0]    base_q,
    input  logic                 end_mark,
    input  logic                 ee_ack,
    output logic                 ee_req,
    output logic                 ee_we,
    output logic [EE_AW-1:0]     ee_addr,
    output logic [BYTE_W-1:0]    ee_wdata,
    output logic [PEND_W-1:0]    done_o,
    output logic                 rd_load,
    output logic                 byte_vld,
    output logic [IDX_W-1:0]     byte_idx,
    output logic [BASE_W-1:0]    base_cap
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REC_BYTES - 1);
    localparam logic [IDX_W-1:0] AW_HI    = IDX_W'(AWORD_W / BYTE_W - 1);

    logic              busy;
    op_e               op;
    op_e               next_op;
    logic [EE_AW-1:0]  cur;
    logic [EE_AW-1:0]  resume;
    logic              touched;
    logic [BYTE_W-1:0] wcap;
    logic [IDX_W-1:0]  idx;
    logic              xfer_done;
    logic              burst_end;

    assign next_op   = pick_op(pend);
    assign xfer_done = busy && ee_ack;
    assign burst_end = (op == OP_BURST) && (idx == AW_HI) && end_mark;

    assign ee_req   = busy;
    assign ee_we    = busy && (op == OP_WRITE);
    assign ee_addr  = cur;
    assign ee_wdata = wcap;
    assign byte_vld = xfer_done && (op == OP_BURST);
    assign byte_idx = idx;

    always_comb begin
        done_o  = '0;
        rd_load = 1'b0;
        if (xfer_done) begin
            case (op)
                OP_WRITE: done_o[PB_WR] = 1'b1;
                OP_READ: begin
                    done_o[PB_RD] = 1'b1;
                    rd_load       = 1'b1;
                end
                OP_BURST: done_o[PB_BST] = burst_end;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            op       <= OP_NONE;
            cur      <= '0;
            resume   <= '0;
            touched  <= 1'b0;
            wcap     <= '0;
            idx      <= '0;
            base_cap <= '0;
        end else if (!busy) begin
            if (next_op != OP_NONE) begin
                busy     <= 1'b1;
                op       <= next_op;
                idx      <= '0;
                wcap     <= data_q;
                base_cap <= base_q;
                if (next_op == OP_BURST)
                    cur <= touched ? resume : '0;
                else
                    cur <= addr_q;
            end
        end else if (ee_ack) begin
            resume  <= cur + EE_AW'(1);
            touched <= 1'b1;
            cur     <= cur + EE_AW'(1);
            if (op != OP_BURST || burst_end)
                busy <= 1'b0;
            else
                idx <= (idx == LAST_IDX) ? '0 : idx + IDX_W'(1);
        end
    end

    // R10: one outstanding byte request, held stable until acknowledged
    a_r10_req_held: assert property (@(posedge clk) disable iff (rst)
        (ee_req && !ee_ack) |=> ee_req && $stable(ee_addr) && $stable(ee_we) && $stable(ee_wdata));

    // R4: the very first burst after reset issues its first request at address 0
    a_r4_first_burst_origin: assert property (@(posedge clk) disable iff (rst)
        (!busy && !touched && next_op == OP_BURST) |=> ee_req && ee_addr == '0);

endmodule

// File: rtl/eep_access_seq.sv
module eep_access_seq
    import eep_pkg::*;
#(
    parameter int EE_AW  = 16,
    parameter int BASE_W = 9,
    localparam int MEM_AW = BASE_W + AWORD_W - 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 hw_en,
    input  logic [SEL_W-1:0]     hw_sel,
    input  logic [HOST_W-1:0]    hw_data,
    input  logic [SEL_W-1:0]     hr_sel,
    output logic [HOST_W-1:0]    hr_data,
    output logic                 ee_req,
    output logic                 ee_we,
    output logic [EE_AW-1:0]     ee_addr,
    output logic [BYTE_W-1:0]    ee_wdata,
    input  logic                 ee_ack,
    input  logic [BYTE_W-1:0]    ee_rdata,
    output logic                 mem_we,
    output logic [MEM_AW-1:0]    mem_addr,
    output logic [DWORD_W-1:0]   mem_wdata
);

    logic [PEND_W-1:0] pend;
    logic [PEND_W-1:0] done;
    logic [EE_AW-1:0]  addr_q;
    logic [BYTE_W-1:0] data_q;
    logic [BASE_W-1:0] base_q;
    logic [BASE_W-1:0] base_cap;
    logic              rd_load;
    logic              byte_vld;
    logic [IDX_W-1:0]  byte_idx;
    logic              end_mark;

    eep_cfg_regs #(.EE_AW(EE_AW), .BASE_W(BASE_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .hw_en   (hw_en),
        .hw_sel  (hw_sel),
        .hw_data (hw_data),
        .hr_sel  (hr_sel),
        .hr_data (hr_data),
        .done_i  (done),
        .rd_load (rd_load),
        .rd_byte (ee_rdata),
        .pend_q  (pend),
        .addr_q  (addr_q),
        .data_q  (data_q),
        .base_q  (base_q)
    );

    eep_seq #(.EE_AW(EE_AW), .BASE_W(BASE_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .pend     (pend),
        .addr_q   (addr_q),
        .data_q   (data_q),
        .base_q   (base_q),
        .end_mark (end_mark),
        .ee_ack   (ee_ack),
        .ee_req   (ee_req),
        .ee_we    (ee_we),
        .ee_addr  (ee_addr),
        .ee_wdata (ee_wdata),
        .done_o   (done),
        .rd_load  (rd_load),
        .byte_vld (byte_vld),
        .byte_idx (byte_idx),
        .base_cap (base_cap)
    );

    eep_rec_pack #(.BASE_W(BASE_W)) u_pack (
        .clk       (clk),
        .rst       (rst),
        .byte_vld  (byte_vld),
        .byte_idx  (byte_idx),
        .byte_in   (ee_rdata),
        .base      (base_cap),
        .end_mark  (end_mark),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    // R9: a byte write on the EEPROM port only happens for a pending write request
    a_r9_write_has_request: assert property (@(posedge clk) disable iff (rst)
        (ee_req && ee_we) |-> pend[PB_WR]);

    // R8: memory writes only occur while the burst request is still open
    a_r8_mem_inside_burst: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> pend[PB_BST]);

endmodule

// File: tb/test_eep_access_seq.sv
module test_eep_access_seq;
    import eep_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hw_en = 1'b0;
    logic [2:0]  hw_sel = '0;
    logic [31:0] hw_data = '0;
    logic [2:0]  hr_sel = '0;
    logic [31:0] hr_data;
    logic        ee_req, ee_we;
    logic [15:0] ee_addr;
    logic [7:0]  ee_wdata;
    logic        ee_ack = 1'b0;
    logic [7:0]  ee_rdata = '0;
    logic        mem_we;
    logic [23:0] mem_addr;
    logic [31:0] mem_wdata;

    always #5 clk = ~clk;

    eep_access_seq i_eep_access_seq (
        .clk(clk), .rst(rst), .hw_en(hw_en), .hw_sel(hw_sel), .hw_data(hw_data),
        .hr_sel(hr_sel), .hr_data(hr_data), .ee_req(ee_req), .ee_we(ee_we),
        .ee_addr(ee_addr), .ee_wdata(ee_wdata), .ee_ack(ee_ack), .ee_rdata(ee_rdata),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [7:0] ee_mem [0:1023];
    int exp_addr[$];
    int exp_we[$];
    int exp_wd[$];
    int exp_maddr[$];
    int exp_mdata[$];
    int lat = 0;
    int nxt = 0;
    bit touched = 0;
    int cur_base = 0;
    string tag = "R1";

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // reference: per-clock monitor of byte transfers and memory writes, plus the EEPROM model
    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            if (mem_we) begin
                if (exp_mdata.size() == 0)
                    check(0, "R8", "unexpected memory write", mem_addr, 0);
                else begin
                    check(mem_addr == 24'(exp_maddr[0]), "R7", "memory address", mem_addr, exp_maddr[0]);
                    check(mem_wdata == 32'(exp_mdata[0]), "R6", "memory data", mem_wdata, exp_mdata[0]);
                    void'(exp_maddr.pop_front());
                    void'(exp_mdata.pop_front());
                end
            end
            if (ee_ack) begin
                ee_ack = 1'b0;
                lat = 0;
            end else if (ee_req) begin
                if (lat >= int'(ee_addr[1:0])) begin
                    if (exp_addr.size() == 0)
                        check(0, tag, "unexpected byte transfer", ee_addr, 0);
                    else begin
                        check(ee_addr == 16'(exp_addr[0]), tag, "transfer address", ee_addr, exp_addr[0]);
                        check(ee_we == exp_we[0][0], tag, "transfer direction", ee_we, exp_we[0]);
                        if (ee_we)
                            check(ee_wdata == 8'(exp_wd[0]), "R2", "write byte", ee_wdata, exp_wd[0]);
                        void'(exp_addr.pop_front());
                        void'(exp_we.pop_front());
                        void'(exp_wd.pop_front());
                    end
                    ee_rdata = ee_mem[ee_addr[9:0]];
                    if (ee_we) ee_mem[ee_addr[9:0]] = ee_wdata;
                    ee_ack = 1'b1;
                end else
                    lat++;
            end
        end
    end

    initial begin
        while (cycles < 100000) @(negedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic host_write(input logic [2:0] sel, input int val);
        @(negedge clk);
        hw_en = 1'b1; hw_sel = sel; hw_data = 32'(val);
        @(negedge clk);
        hw_en = 1'b0;
    endtask

    task automatic host_read(input logic [2:0] sel, output int val);
        hr_sel = sel;
        #1 val = int'(hr_data);
    endtask

    task automatic wait_idle();
        int c, b;
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            host_read(RSEL_CTRL, c);
            host_read(RSEL_BURST, b);
            if (c == 0 && b == 0) break;
        end
    endtask

    task automatic expect_xfer(input int a, input int we, input int wd);
        exp_addr.push_back(a); exp_we.push_back(we); exp_wd.push_back(wd);
    endtask

    task automatic expect_burst();
        int a = touched ? nxt : 0;
        int aw, dw;
        forever begin
            expect_xfer(a, 0, 0); expect_xfer(a + 1, 0, 0);
            aw = int'(ee_mem[a]) | (int'(ee_mem[a + 1]) << 8);
            a += 2;
            if (aw == 'hFFFF) break;
            dw = 0;
            for (int k = 0; k < 4; k++) begin
                expect_xfer(a + k, 0, 0);
                dw |= int'(ee_mem[a + k]) << (8 * k);
            end
            a += 4;
            exp_maddr.push_back(((cur_base & 'h1FF) << 15) | (aw & 'h7FFF));
            exp_mdata.push_back(dw);
        end
        nxt = a;
        touched = 1;
    endtask

    task automatic put_rec(input int a, input int aw, input int dw);
        ee_mem[a] = 8'(aw); ee_mem[a + 1] = 8'(aw >> 8);
        for (int k = 0; k < 4; k++) ee_mem[a + 2 + k] = 8'(dw >> (8 * k));
    endtask

    task automatic put_end(input int a);
        ee_mem[a] = 8'hFF; ee_mem[a + 1] = 8'hFF;
    endtask

    initial begin
        int v;
        for (int i = 0; i < 1024; i++) ee_mem[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        for (int s = 0; s < 5; s++) begin
            host_read(3'(s), v);
            check(v == 0, "R1", "register after reset", v, 0);
        end
        check(ee_req == 1'b0 && mem_we == 1'b0, "R1", "idle outputs", {ee_req, mem_we}, 0);

        // R4 R6 R7 R8: first burst starts at 0; bit 15 of the destination is dropped
        tag = "R4";
        put_rec(0, 'h8012, 'h11223344);
        put_rec(6, 'h0005, 'hD8C7B6A5);
        put_end(12);
        cur_base = 'h1A5;
        host_write(RSEL_BASE, cur_base);
        expect_burst();
        host_write(RSEL_BURST, 1);
        host_read(RSEL_BURST, v);
        check(v == 1, "R8", "burst bit while running", v, 1);
        wait_idle();
        host_read(RSEL_BURST, v);
        check(v == 0, "R8", "burst bit self-clears", v, 0);

        // R2: single write; writing 0 first must do nothing
        tag = "R2";
        host_write(RSEL_CTRL, 0);
        repeat (6) @(negedge clk);
        host_write(RSEL_ADDR, 100);
        host_write(RSEL_DATA, 'h5C);
        expect_xfer(100, 1, 'h5C);
        host_write(RSEL_CTRL, 1);
        host_read(RSEL_CTRL, v);
        check(v == 1, "R2", "write bit while busy", v, 1);
        wait_idle();
        host_read(RSEL_CTRL, v);
        check(v == 0, "R2", "write bit clears", v, 0);
        nxt = 101;

        // R3: single read returns the byte written
        tag = "R3";
        host_write(RSEL_DATA, 0);
        expect_xfer(100, 0, 0);
        host_write(RSEL_CTRL, 2);
        wait_idle();
        host_read(RSEL_DATA, v);
        check(v == 'h5C, "R3", "read data", v, 'h5C);
        nxt = 101;

        // R5: burst after a single access resumes at address+1
        tag = "R5";
        put_rec(101, 'h0007, 'hDEADBEEF);
        put_end(107);
        cur_base = 'h0FF;
        host_write(RSEL_BASE, cur_base);
        expect_burst();
        host_write(RSEL_BURST, 1);
        wait_idle();

        // R5 R8: burst after burst, immediate end marker, no memory write
        put_end(109);
        expect_burst();
        host_write(RSEL_BURST, 1);
        wait_idle();

        // R9: write, read and burst pending together are served in order
        tag = "R9";
        host_write(RSEL_ADDR, 200);
        host_write(RSEL_DATA, 'h77);
        put_end(201);
        expect_xfer(200, 1, 'h77);
        expect_xfer(200, 0, 0);
        touched = 1; nxt = 201;
        expect_burst();
        host_write(RSEL_CTRL, 3);
        host_read(RSEL_CTRL, v);
        check(v == 3, "R9", "both requests held", v, 3);
        host_write(RSEL_BURST, 1);
        wait_idle();
        host_read(RSEL_DATA, v);
        check(v == 'h77, "R9", "read after write", v, 'h77);

        repeat (5) @(negedge clk);
        check(exp_addr.size() == 0, "R10", "byte transfers left over", exp_addr.size(), 0);
        check(exp_mdata.size() == 0, "R6", "memory writes left over", exp_mdata.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule